// File: doc/BRIEF.md
# Serial EEPROM Command Front End

This block is the slave side of a three-wire clocked serial memory link. A host drives an active-low select, a serial clock and a serial data line. The block samples all three with its own system clock and decodes the frames that arrive. A frame carries an 8-bit operation code, an 8-bit address field and a 16-bit data word. Read commands are served from a 128-word by 16-bit array inside the block. The block streams words one after another for as long as the host keeps clocking. Write commands and the enable/disable commands go out as one-cycle requests to a separate write controller. That controller also loads the array through a plain write port.

The level of the serial clock at the instant select falls sets the mode for that select window. A high clock starts command reception. A low clock starts status output, where the data pin reports whether the write controller is idle. The serial data output is a data bit plus an output enable, so a pad or a checker can model the tri-state.

Top module: `sereep_front`

## Requirements
- R1: After reset, `sdo_en` is 0 and none of `prog_req`, `wen_on` or `wen_off` is asserted.
- R2: When `sel_n` falls while `sclk` is low, the block enters status output. `sdo_en` goes to 1 and `sdo` follows the inverse of `prog_busy` (1 = ready, 0 = busy) until `sel_n` rises.
- R3: When `sel_n` falls while `sclk` is high, the block receives a command. `sdi` is taken on each `sclk` rising edge, MSB first: 8 op-code bits, then the address field (A6..A0 followed by one don't-care bit), then 16 data bits. Op-codes: read 10101000, write 10100100, enable 10100011, disable 10100000.
- R4: For a read, `sdo_en` stays 0 through the 16th rising edge. From the 17th falling edge on, each falling edge presents the next bit of the addressed word, D15 first.
- R5: After every 16 output bits the read address increments by one and wraps from 0x7F to 0x00, so output continues without limit.
- R6: A write command produces exactly one `prog_req` pulse, and only after the 32nd rising edge. `prog_addr` and `prog_data` carry the received address and word.
- R7: The enable and disable commands produce one `wen_on` or one `wen_off` pulse after the 16th rising edge.
- R8: If `sel_n` rises before a frame completes, or during read output, the command is dropped. No request is issued and `sdo_en` returns to 0.
- R9: An unrecognised op-code, including 10101111, causes no request and no output for the rest of that frame.
- R10: `sdo_en` is 0 whenever the block is neither in read output nor in status output, and in particular while `sel_n` is high.
- R11: A word written through `ld_we`/`ld_addr`/`ld_data` is returned by a later read of that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Serial select, active low, asynchronous |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data in, asynchronous |
| sdo | output | 1 | Serial data out value |
| sdo_en | output | 1 | Output enable for sdo (0 = high impedance) |
| prog_busy | input | 1 | Write controller busy flag, shown in status mode |
| prog_req | output | 1 | One-cycle write request |
| prog_addr | output | 7 | Word address of the write request |
| prog_data | output | 16 | Data word of the write request |
| wen_on | output | 1 | One-cycle write-enable command |
| wen_off | output | 1 | One-cycle write-disable command |
| ld_we | input | 1 | Array load strobe from the write controller |
| ld_addr | input | 7 | Array load address |
| ld_data | input | 16 | Array load word |

## Verification
A wrong bit counter or a wrong shift register shows up at the serial output as a misaligned or corrupted word. It can also appear as a request with a wrong address or data, or at the wrong edge count. Each of these is visible within the frame that caused it. A fault in the read address register is seen only when the second word of a sequential read comes out, or at the wrap from the top address. A fault in the mode choice at select fall shows up as `sdo_en` rising at once in place of after 16 edges, or not rising at all. A mode held past select rising leaves `sdo_en` high a few system clocks after the host has released the link.

// File: rtl/sfe_pkg.sv
package sfe_pkg;
  localparam logic [7:0] OPC_READ  = 8'b1010_1000;
  localparam logic [7:0] OPC_WRITE = 8'b1010_0100;
  localparam logic [7:0] OPC_WEN   = 8'b1010_0011;
  localparam logic [7:0] OPC_WDIS  = 8'b1010_0000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RECV,
    ST_RDOUT,
    ST_STATUS,
    ST_SKIP
  } fe_state_t;
endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] s1, s2, s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= RST_VAL;
      s2 <= RST_VAL;
      s3 <= RST_VAL;
    end else begin
      s1 <= d;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign q      = s2;
  assign q_prev = s3;
endmodule

// File: rtl/sfe_wordram.sv
module sfe_wordram #(
  parameter int ADDR_W = 7,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[waddr] <= wdata;
    rdata <= arr[raddr];
  end
endmodule

// File: rtl/sfe_frame.sv
module sfe_frame
  import sfe_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int WORD_W  = 16,
  parameter int OP_W    = 8,
  parameter int FIELD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_hi,
  input  logic              cs_fall,
  input  logic              sk_lvl,
  input  logic              sk_rise,
  input  logic              sk_fall,
  input  logic              di,
  input  logic              busy,
  input  logic [WORD_W-1:0] mem_q,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              dout,
  output logic              dout_en,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              en_set,
  output logic              en_clr
);
  localparam int HDR_W   = OP_W + FIELD_W;
  localparam int FRAME_W = HDR_W + WORD_W;
  localparam int CNT_W   = $clog2(FRAME_W) + 1;
  localparam int OC_W    = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(HDR_W - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FRAME_W - 1);
  localparam logic [OC_W-1:0]  OC_LAST  = OC_W'(WORD_W - 1);

  fe_state_t          state;
  logic [CNT_W-1:0]   cnt;
  logic [FRAME_W-1:0] sr;
  logic [FRAME_W-1:0] nxt;
  logic [WORD_W-1:0]  osr;
  logic [OC_W-1:0]    ocnt;

  logic [OP_W-1:0]    hdr_op, end_op;
  logic [FIELD_W-1:0] hdr_fld, end_fld;
  logic               unused_bits;

  assign nxt     = {sr[FRAME_W-2:0], di};
  assign hdr_op  = nxt[HDR_W-1 -: OP_W];
  assign hdr_fld = nxt[FIELD_W-1:0];
  assign end_op  = nxt[FRAME_W-1 -: OP_W];
  assign end_fld = nxt[WORD_W+FIELD_W-1 -: FIELD_W];
  assign unused_bits = ^{hdr_fld[FIELD_W-ADDR_W-1:0], end_fld[FIELD_W-ADDR_W-1:0], end_op};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      sr      <= '0;
      osr     <= '0;
      ocnt    <= '0;
      rd_addr <= '0;
      dout    <= 1'b0;
      dout_en <= 1'b0;
      wr_req  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      en_set  <= 1'b0;
      en_clr  <= 1'b0;
    end else begin
      wr_req <= 1'b0;
      en_set <= 1'b0;
      en_clr <= 1'b0;
      if (cs_hi) begin
        state   <= ST_IDLE;
        dout_en <= 1'b0;
      end else begin
        case (state)
          ST_IDLE: begin
            dout_en <= 1'b0;
            if (cs_fall) begin
              if (sk_lvl) begin
                state <= ST_RECV;
                cnt   <= '0;
              end else begin
                state   <= ST_STATUS;
                dout_en <= 1'b1;
                dout    <= ~busy;
              end
            end
          end
          ST_RECV: begin
            if (sk_rise) begin
              sr  <= nxt;
              cnt <= cnt + 1'b1;
              if (cnt == CNT_HDR) begin
                case (hdr_op)
                  OPC_READ: begin
                    state   <= ST_RDOUT;
                    rd_addr <= hdr_fld[FIELD_W-1 -: ADDR_W];
                    ocnt    <= '0;
                  end
                  OPC_WEN: begin
                    en_set <= 1'b1;
                    state  <= ST_SKIP;
                  end
                  OPC_WDIS: begin
                    en_clr <= 1'b1;
                    state  <= ST_SKIP;
                  end
                  OPC_WRITE: state <= ST_RECV;
                  default:   state <= ST_SKIP;
                endcase
              end else if (cnt == CNT_LAST) begin
                wr_req  <= 1'b1;
                wr_addr <= end_fld[FIELD_W-1 -: ADDR_W];
                wr_data <= nxt[WORD_W-1:0];
                state   <= ST_SKIP;
              end
            end
          end
          ST_RDOUT: begin
            if (sk_fall) begin
              dout_en <= 1'b1;
              if (ocnt == '0) begin
                dout    <= mem_q[WORD_W-1];
                osr     <= {mem_q[WORD_W-2:0], 1'b0};
                ocnt    <= OC_LAST;
                rd_addr <= rd_addr + 1'b1;
              end else begin
                dout <= osr[WORD_W-1];
                osr  <= {osr[WORD_W-2:0], 1'b0};
                ocnt <= ocnt - 1'b1;
              end
            end
          end
          ST_STATUS: begin
            dout_en <= 1'b1;
            dout    <= ~busy;
          end
          default: ;
        endcase
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    cs_hi |=> !dout_en); // R10

  AST_OE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_en) |-> ($past(sk_fall) || $past(cs_fall))); // R4

  AST_REQ_EDGE: assert property (@(posedge clk) disable iff (rst)
    (wr_req || en_set || en_clr) |-> $past(sk_rise) && !$past(cs_hi)); // R8

  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> !wr_req); // R6

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (rst)
    $onehot0({wr_req, en_set, en_clr})); // R7
endmodule

// File: rtl/sereep_front.sv
module sereep_front #(
  parameter int ADDR_W  = 7,
  parameter int WORD_W  = 16,
  parameter int OP_W    = 8,
  parameter int FIELD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_en,
  input  logic              prog_busy,
  output logic              prog_req,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [WORD_W-1:0] prog_data,
  output logic              wen_on,
  output logic              wen_off,
  input  logic              ld_we,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [WORD_W-1:0] ld_data
);
  logic [2:0]        pin_q, pin_p;
  logic [ADDR_W-1:0] rd_addr;
  logic [WORD_W-1:0] mem_q;

  sfe_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .d      ({sdi, sclk, sel_n}),
    .q      (pin_q),
    .q_prev (pin_p)
  );

  sfe_wordram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
    .clk   (clk),
    .we    (ld_we),
    .waddr (ld_addr),
    .wdata (ld_data),
    .raddr (rd_addr),
    .rdata (mem_q)
  );

  sfe_frame #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .OP_W(OP_W), .FIELD_W(FIELD_W)
  ) u_frame (
    .clk     (clk),
    .rst     (rst),
    .cs_hi   (pin_q[0]),
    .cs_fall (pin_p[0] & ~pin_q[0]),
    .sk_lvl  (pin_q[1]),
    .sk_rise (pin_q[1] & ~pin_p[1]),
    .sk_fall (~pin_q[1] & pin_p[1]),
    .di      (pin_q[2]),
    .busy    (prog_busy),
    .mem_q   (mem_q),
    .rd_addr (rd_addr),
    .dout    (sdo),
    .dout_en (sdo_en),
    .wr_req  (prog_req),
    .wr_addr (prog_addr),
    .wr_data (prog_data),
    .en_set  (wen_on),
    .en_clr  (wen_off)
  );
endmodule

// File: tb/sereep_front_bench.sv
module sereep_front_bench;
  localparam int H = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic sel_n = 1'b1, sclk = 1'b0, sdi = 1'b0, prog_busy = 1'b0;
  logic ld_we = 1'b0;
  logic [6:0]  ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic sdo, sdo_en, prog_req, wen_on, wen_off;
  logic [6:0]  prog_addr;
  logic [15:0] prog_data;

  int checks = 0, failures = 0, cycles = 0;
  logic [24:0] exp_q[$];
  logic [15:0] model [128];
  bit done = 0;

  always #10 clk = ~clk;

  sereep_front u_sereep_front (
    .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en), .prog_busy(prog_busy),
    .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
    .wen_on(wen_on), .wen_off(wen_off),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard whenever a request pulse appears
  always @(negedge clk) begin
    if (!rst && (prog_req || wen_on || wen_off)) begin
      logic [24:0] got;
      logic [24:0] e;
      if (prog_req) got = {2'd1, prog_addr, prog_data};
      else if (wen_on) got = {2'd2, 7'd0, 16'd0};
      else got = {2'd3, 7'd0, 16'd0};
      if (exp_q.size() == 0) begin
        check(1'b0, "R8/R9 unexpected request", 32'(got), 32'd0);
      end else begin
        e = exp_q.pop_front();
        check(got == e, (e[24:23] == 2'd1) ? "R6 write request" : "R7 enable/disable",
              32'(got), 32'(e));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic start_cmd();
    sclk = 1'b1; waitc(H);
    sel_n = 1'b0; waitc(H);
  endtask

  task automatic end_frame();
    sel_n = 1'b1; waitc(2*H);
  endtask

  task automatic shift_bit(input logic b);
    sclk = 1'b0; sdi = b; waitc(H);
    sclk = 1'b1; waitc(H);
  endtask

  task automatic send(input logic [7:0] op, input logic [6:0] a, input logic [15:0] d, input int nbits);
    logic [31:0] f;
    f = {op, a, 1'b0, d};
    start_cmd();
    for (int i = 0; i < nbits; i++) shift_bit(f[31-i]);
    end_frame();
  endtask

  task automatic read_words(input logic [6:0] a, input int n);
    logic [15:0] w;
    logic [15:0] fld;
    bit oe_ok;
    fld = {8'b1010_1000, a, 1'b0};
    start_cmd();
    for (int i = 0; i < 16; i++) shift_bit(fld[15-i]);
    check(sdo_en == 1'b0, "R4 high-Z before 17th fall", 32'(sdo_en), 32'd0);
    for (int k = 0; k < n; k++) begin
      oe_ok = 1;
      for (int b = 15; b >= 0; b--) begin
        sclk = 1'b0; waitc(H);
        w[b] = sdo;
        if (sdo_en !== 1'b1) oe_ok = 0;
        sclk = 1'b1; waitc(H);
      end
      check(oe_ok, "R4 output enabled during read", 32'(oe_ok), 32'd1);
      check(w == model[7'(a + k)], (k > 0) ? "R5 sequential word" : "R3/R4 read word",
            32'(w), 32'(model[7'(a + k)]));
    end
    end_frame();
    check(sdo_en == 1'b0, "R10 high-Z after select release", 32'(sdo_en), 32'd0);
  endtask

  task automatic load(input logic [6:0] a, input logic [15:0] d);
    ld_we = 1'b1; ld_addr = a; ld_data = d; model[a] = d;
    waitc(1);
    ld_we = 1'b0;
  endtask

  initial begin
    waitc(5);
    rst = 1'b0;
    waitc(2);
    check(sdo_en == 1'b0 && !prog_req && !wen_on && !wen_off, "R1 reset state",
          32'({sdo_en, prog_req, wen_on, wen_off}), 32'd0);

    for (int i = 0; i < 128; i++) load(7'(i), 16'(i * 16'h0101) ^ 16'h5A3C);

    // R2 status output
    sclk = 1'b0; waitc(H);
    sel_n = 1'b0; waitc(H);
    check(sdo_en == 1'b1 && sdo == 1'b1, "R2 status ready", 32'({sdo_en, sdo}), 32'h3);
    prog_busy = 1'b1; waitc(H);
    check(sdo_en == 1'b1 && sdo == 1'b0, "R2 status busy", 32'({sdo_en, sdo}), 32'h2);
    sel_n = 1'b1; waitc(H);
    check(sdo_en == 1'b0, "R10 status ends on select high", 32'(sdo_en), 32'd0);
    prog_busy = 1'b0;

    read_words(7'h05, 2);   // R3 R4 R5
    read_words(7'h7E, 3);   // R5 wrap

    exp_q.push_back({2'd2, 7'd0, 16'd0});
    send(8'b1010_0011, 7'h00, 16'h0000, 16);   // R7 enable
    exp_q.push_back({2'd3, 7'd0, 16'd0});
    send(8'b1010_0000, 7'h00, 16'h0000, 16);   // R7 disable
    check(exp_q.size() == 0, "R7 commands issued", 32'(exp_q.size()), 32'd0);

    exp_q.push_back({2'd1, 7'h33, 16'hBEEF});
    send(8'b1010_0100, 7'h33, 16'hBEEF, 32);   // R6
    check(exp_q.size() == 0, "R6 write issued", 32'(exp_q.size()), 32'd0);

    send(8'b1010_0100, 7'h12, 16'h1234, 31);   // R8 dropped one bit short
    check(sdo_en == 1'b0, "R8 abandoned write quiet", 32'(sdo_en), 32'd0);

    // R8 read abandoned mid-word
    begin
      logic [15:0] fld;
      fld = {8'b1010_1000, 7'h10, 1'b0};
      start_cmd();
      for (int i = 0; i < 16; i++) shift_bit(fld[15-i]);
      for (int i = 0; i < 5; i++) shift_bit(1'b0);
      check(sdo_en == 1'b1, "R8 read was outputting", 32'(sdo_en), 32'd1);
      end_frame();
      check(sdo_en == 1'b0, "R8 read dropped", 32'(sdo_en), 32'd0);
    end

    send(8'b1010_1111, 7'h22, 16'hFFFF, 32);   // R9 test code ignored
    check(sdo_en == 1'b0, "R9 ignored op no output", 32'(sdo_en), 32'd0);
    send(8'b0101_0101, 7'h01, 16'h0F0F, 32);   // R9 junk code
    check(exp_q.size() == 0, "R9 no request", 32'(exp_q.size()), 32'd0);

    load(7'h40, 16'hC0DE);                     // R11
    read_words(7'h40, 1);

    waitc(4);
    finish_run();
  end
endmodule